// File: doc/BRIEF.md
# Range-Matching Translation Buffer with Pinned Block Slots

This block is a small fully associative address translation buffer. Every slot holds one mapping from a virtual range to a physical base, and that range is a 4 KB page scaled by a power of four. A lookup is a purely combinational search of all valid slots. Any address that falls between a slot's first and last byte hits that slot. The lookup returns the physical address and the stored flag bits.

The lowest slots are pinned block slots. Ordinary purges and replacement never touch them. Only dedicated block commands, which address a slot by its index, can write or clear them. The remaining slots are filled by ordinary inserts. An insert takes the lowest-numbered free slot first. When no slot is free, it evicts the slot chosen by a round-robin pointer. Before each insert, any ordinary slot whose range overlaps the new range is invalidated. A command that arrives with `cmd_valid` takes effect at the next rising clock edge.

Top module: `tlb_range_pinned`

## Requirements
- R1: An ordinary insert (`cmd_op`=1) with size code s covers 2^(12+2s) bytes. Its base is `cmd_va` aligned down to that size. If the span would reach 2^VA_W bytes, the entry covers the whole address space. A lookup hits when base <= `lk_va` <= last. It then returns `lk_pa` = stored physical base + (`lk_va` - base), together with the stored `lk_attr`, `lk_dirty` and `lk_trap`.
- R2: The stored physical base is `cmd_pa` with the same low-bit mask cleared as the virtual base. Bits PA_W and above are replaced by copies of bit PA_W-1.
- R3: An insert (ordinary or block) first invalidates every valid ordinary slot whose range overlaps the new range. After that, a lookup in the overlapped area returns the new entry.
- R4: A range purge (`cmd_op`=2) builds its range from `cmd_va`. The start is `cmd_va` with bits [11:0] cleared. The size code is `cmd_va[3:0]`. The range runs from the start to start + 2^(12+2s) - 1, saturating at the top of the address space. The purge invalidates every valid ordinary slot that overlaps this range and leaves block slots valid.
- R5: An ordinary insert goes to the lowest-numbered invalid ordinary slot (indices NBLK..SLOTS-1). Slots freed by the insert's own overlap purge count as free. `lk_slot` reports the index of the slot that hit.
- R6: When no ordinary slot is free, an insert evicts the slot named by a round-robin pointer. The pointer starts at NBLK after reset and advances by one per eviction. After SLOTS-1 it wraps back to NBLK. It does not move when a free slot is used.
- R7: Purge-all (`cmd_op`=3) invalidates every ordinary slot, resets the round-robin pointer to NBLK and keeps all block slots.
- R8: A block insert (`cmd_op`=4) with `cmd_slot` < NBLK writes that slot using the R1/R2 rules and replaces its previous content. It stores dirty=1 and trap=0 whatever `cmd_dirty` and `cmd_trap` carry.
- R9: A block insert or block purge with `cmd_slot` >= NBLK is rejected and changes no slot. `cmd_rej` is 1 in the cycle after a rejected command and 0 after any other command.
- R10: Block purge (`cmd_op`=5) invalidates block slot `cmd_slot`. Block purge-all (`cmd_op`=6) invalidates every block slot and keeps all ordinary slots.
- R11: When several slots hit, the lowest index wins. On a miss, `lk_hit`, `lk_slot`, `lk_pa`, `lk_attr`, `lk_dirty` and `lk_trap` are all 0. At most one ordinary slot can hit any address.
- R12: After reset no slot is valid, so every lookup misses, and `cmd_rej` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 insert, 2 range purge, 3 purge-all, 4 block insert, 5 block purge, 6 block purge-all |
| cmd_va | input | VA_W | Virtual address; for a range purge, bits [3:0] hold the size code |
| cmd_size | input | 4 | Size code for inserts |
| cmd_pa | input | PA_IN_W | Physical address for inserts |
| cmd_attr | input | ATTR_W | Attribute bits stored with the entry |
| cmd_dirty | input | 1 | Dirty flag for ordinary inserts |
| cmd_trap | input | 1 | Reference-trap flag for ordinary inserts |
| cmd_slot | input | log2(SLOTS) | Slot index for block commands |
| cmd_rej | output | 1 | Previous block command was rejected |
| lk_va | input | VA_W | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | log2(SLOTS) | Index of the slot that hit |
| lk_pa | output | PA_IN_W | Translated physical address |
| lk_attr | output | ATTR_W | Attribute bits of the slot that hit |
| lk_dirty | output | 1 | Dirty flag of the slot that hit |
| lk_trap | output | 1 | Reference-trap flag of the slot that hit |

## Verification
Lookups and commands share a cycle: a lookup runs every cycle, including a cycle in which a purge or insert changing the same range is pending. The bench holds a lookup address on a slot while it strobes a purge of that range. It expects a hit before the clock edge, because the lookup sees the old contents, and a miss after the edge. The second same-cycle interplay is an insert whose overlap purge frees the slot that the same insert then claims. It is exercised both directly and by random traffic packed into a few narrow address windows, and every lookup is compared against a reference model of the slot contents.

// File: rtl/tlb_rp_pkg.sv
package tlb_rp_pkg;
  localparam int SZ_W    = 4;
  localparam int PG_BITS = 12;

  typedef enum logic [2:0] {
    OP_NOP           = 3'd0,
    OP_INSERT        = 3'd1,
    OP_PURGE         = 3'd2,
    OP_PURGE_ALL     = 3'd3,
    OP_BLK_INSERT    = 3'd4,
    OP_BLK_PURGE     = 3'd5,
    OP_BLK_PURGE_ALL = 3'd6
  } tlb_op_e;
endpackage

// File: rtl/tlb_span.sv
// Turns an address and a power-of-four size code into an inclusive range.
// ALIGN=1 aligns the start down to the span; ALIGN=0 aligns it to a page.
module tlb_span
  import tlb_rp_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter bit ALIGN = 1'b1
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [SZ_W-1:0] size_i,
  output logic [VA_W-1:0] lo_o,
  output logic [VA_W-1:0] hi_o
);
  localparam logic [VA_W-1:0] PG_MASK = VA_W'((64'd1 << PG_BITS) - 64'd1);

  logic [VA_W-1:0] span_mask;
  logic [VA_W-1:0] lo_mask;
  logic [VA_W:0]   sum;
  int              sh;

  always_comb begin
    sh = PG_BITS + 2 * int'(size_i);
    if (sh >= VA_W) span_mask = '1;
    else            span_mask = ~({VA_W{1'b1}} << sh);
  end

  assign lo_mask = ALIGN ? span_mask : PG_MASK;
  assign lo_o    = va_i & ~lo_mask;
  assign sum     = {1'b0, lo_o} + {1'b0, span_mask};
  assign hi_o    = sum[VA_W] ? '1 : sum[VA_W-1:0];
endmodule

// File: rtl/tlb_victim.sv
// Chooses the slot for an ordinary insert: lowest free ordinary slot first,
// else the round-robin pointer over ordinary slots.
module tlb_victim #(
  parameter int SLOTS = 16,
  parameter int NBLK  = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] valid_i,
  input  logic             alloc_i,
  input  logic             rr_clr_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [SLOTS-1:0] NB_MASK = {SLOTS{1'b1}} << NBLK;

  logic [SLOTS-1:0] free_map;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic [IDX_W-1:0] rr_q, rr_d;

  assign free_map = ~valid_i & NB_MASK;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_map[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_o = any_free ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (rr_clr_i)
      rr_d = IDX_W'(NBLK);
    else if (alloc_i && !any_free)
      rr_d = (rr_q == IDX_W'(SLOTS - 1)) ? IDX_W'(NBLK) : rr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rr_q <= IDX_W'(NBLK);
    else         rr_q <= rr_d;
  end

  AST_RR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    rr_q >= IDX_W'(NBLK)); // R6
  AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
    (alloc_i && !rr_clr_i && ((valid_i & NB_MASK) == NB_MASK)) |=> rr_q != $past(rr_q)); // R6
  AST_RR_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    rr_clr_i |=> rr_q == IDX_W'(NBLK)); // R7
endmodule

// File: rtl/tlb_match.sv
// Parallel range compare over all slots; the lowest-index hit drives the outputs.
module tlb_match #(
  parameter int SLOTS   = 16,
  parameter int VA_W    = 32,
  parameter int PA_IN_W = 40,
  parameter int ATTR_W  = 8,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]   valid_i,
  input  logic [VA_W-1:0]    base_i [SLOTS],
  input  logic [VA_W-1:0]    last_i [SLOTS],
  input  logic [PA_IN_W-1:0] pa_i   [SLOTS],
  input  logic [ATTR_W-1:0]  attr_i [SLOTS],
  input  logic [SLOTS-1:0]   dirty_i,
  input  logic [SLOTS-1:0]   trap_i,
  input  logic [VA_W-1:0]    va_i,
  output logic [SLOTS-1:0]   hit_vec_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   slot_o,
  output logic [PA_IN_W-1:0] pa_o,
  output logic [ATTR_W-1:0]  attr_o,
  output logic               dirty_o,
  output logic               trap_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (base_i[g] <= va_i) && (va_i <= last_i[g]);
  end

  always_comb begin
    hit_o   = 1'b0;
    slot_o  = '0;
    pa_o    = '0;
    attr_o  = '0;
    dirty_o = 1'b0;
    trap_o  = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) begin
        hit_o   = 1'b1;
        slot_o  = IDX_W'(i);
        pa_o    = pa_i[i] + PA_IN_W'(va_i - base_i[i]);
        attr_o  = attr_i[i];
        dirty_o = dirty_i[i];
        trap_o  = trap_i[i];
      end
    end
  end
endmodule

// File: rtl/tlb_range_pinned.sv
module tlb_range_pinned
  import tlb_rp_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int NBLK    = 4,
  parameter int VA_W    = 32,
  parameter int PA_IN_W = 40,
  parameter int PA_W    = 36,
  parameter int ATTR_W  = 8,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [VA_W-1:0]    cmd_va,
  input  logic [SZ_W-1:0]    cmd_size,
  input  logic [PA_IN_W-1:0] cmd_pa,
  input  logic [ATTR_W-1:0]  cmd_attr,
  input  logic               cmd_dirty,
  input  logic               cmd_trap,
  input  logic [IDX_W-1:0]   cmd_slot,
  output logic               cmd_rej,
  input  logic [VA_W-1:0]    lk_va,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_slot,
  output logic [PA_IN_W-1:0] lk_pa,
  output logic [ATTR_W-1:0]  lk_attr,
  output logic               lk_dirty,
  output logic               lk_trap
);
  localparam logic [SLOTS-1:0] NB_MASK  = {SLOTS{1'b1}} << NBLK;
  localparam logic [SLOTS-1:0] BLK_MASK = ~NB_MASK;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // slot storage
  logic [SLOTS-1:0]   valid_q, valid_d;
  logic [VA_W-1:0]    base_q [SLOTS];
  logic [VA_W-1:0]    last_q [SLOTS];
  logic [PA_IN_W-1:0] pa_q   [SLOTS];
  logic [ATTR_W-1:0]  attr_q [SLOTS];
  logic [SLOTS-1:0]   dirty_q, trap_q;
  logic               rej_q, rej_d;

  // command ranges
  logic [VA_W-1:0] ins_lo, ins_hi, prg_lo, prg_hi, rng_lo, rng_hi;
  tlb_span #(.VA_W(VA_W), .ALIGN(1'b1)) u_ins_span (
    .va_i(cmd_va), .size_i(cmd_size), .lo_o(ins_lo), .hi_o(ins_hi));
  tlb_span #(.VA_W(VA_W), .ALIGN(1'b0)) u_prg_span (
    .va_i(cmd_va), .size_i(cmd_va[SZ_W-1:0]), .lo_o(prg_lo), .hi_o(prg_hi));

  tlb_op_e op;
  logic    slot_ok;
  assign op      = tlb_op_e'(cmd_op);
  assign slot_ok = int'(cmd_slot) < NBLK;
  assign rng_lo  = (op == OP_PURGE) ? prg_lo : ins_lo;
  assign rng_hi  = (op == OP_PURGE) ? prg_hi : ins_hi;

  logic [SLOTS-1:0] ov_vec, purge_nb;
  for (genvar g = 0; g < SLOTS; g++) begin : g_ovl
    assign ov_vec[g] = valid_q[g] && (base_q[g] <= rng_hi) && (rng_lo <= last_q[g]);
  end
  assign purge_nb = ov_vec & NB_MASK;

  // physical base: same alignment, then sign-extend from PA_W
  logic [PA_IN_W-1:0] pa_mask, pa_al, w_pa;
  assign pa_mask = PA_IN_W'(ins_hi ^ ins_lo);
  assign pa_al   = cmd_pa & ~pa_mask;
  if (PA_W < PA_IN_W) begin : g_sext
    assign w_pa = {{(PA_IN_W - PA_W){pa_al[PA_W-1]}}, pa_al[PA_W-1:0]};
  end else begin : g_nosext
    assign w_pa = pa_al;
  end

  // victim selection
  logic             alloc_en, rr_clr;
  logic [IDX_W-1:0] victim;
  tlb_victim #(.SLOTS(SLOTS), .NBLK(NBLK)) u_victim (
    .clk(clk), .rst_ni(rst_ni), .valid_i(valid_q & ~purge_nb),
    .alloc_i(alloc_en), .rr_clr_i(rr_clr), .victim_o(victim));

  // next state
  logic             we, wblk;
  logic [IDX_W-1:0] wslot;
  always_comb begin
    valid_d  = valid_q;
    rej_d    = 1'b0;
    we       = 1'b0;
    wblk     = 1'b0;
    wslot    = victim;
    alloc_en = 1'b0;
    rr_clr   = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_INSERT: begin
          valid_d  = valid_q & ~purge_nb;
          alloc_en = 1'b1;
          we       = 1'b1;
        end
        OP_PURGE:     valid_d = valid_q & ~purge_nb;
        OP_PURGE_ALL: begin
          valid_d = valid_q & BLK_MASK;
          rr_clr  = 1'b1;
        end
        OP_BLK_INSERT: begin
          if (slot_ok) begin
            valid_d = valid_q & ~purge_nb;
            we      = 1'b1;
            wblk    = 1'b1;
            wslot   = cmd_slot;
          end else begin
            rej_d = 1'b1;
          end
        end
        OP_BLK_PURGE: begin
          if (slot_ok) valid_d[cmd_slot] = 1'b0;
          else         rej_d = 1'b1;
        end
        OP_BLK_PURGE_ALL: valid_d = valid_q & NB_MASK;
        default: ;
      endcase
    end
    if (we) valid_d[wslot] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rej_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      rej_q   <= rej_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      base_q[wslot]  <= ins_lo;
      last_q[wslot]  <= ins_hi;
      pa_q[wslot]    <= w_pa;
      attr_q[wslot]  <= cmd_attr;
      dirty_q[wslot] <= wblk | cmd_dirty;
      trap_q[wslot]  <= ~wblk & cmd_trap;
    end
  end

  assign cmd_rej = rej_q;

  // lookup
  logic [SLOTS-1:0] hit_vec;
  tlb_match #(.SLOTS(SLOTS), .VA_W(VA_W), .PA_IN_W(PA_IN_W), .ATTR_W(ATTR_W)) u_match (
    .valid_i(valid_q), .base_i(base_q), .last_i(last_q), .pa_i(pa_q), .attr_i(attr_q),
    .dirty_i(dirty_q), .trap_i(trap_q), .va_i(lk_va), .hit_vec_o(hit_vec),
    .hit_o(lk_hit), .slot_o(lk_slot), .pa_o(lk_pa), .attr_o(lk_attr),
    .dirty_o(lk_dirty), .trap_o(lk_trap));

  AST_NB_UNIQUE: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(hit_vec & NB_MASK)); // R11
  AST_PURGE_KEEPS_BLK: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && op == OP_PURGE) |=> $stable(valid_q & BLK_MASK)); // R4
  AST_PURGE_ALL_NB: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && op == OP_PURGE_ALL) |=> ((valid_q & NB_MASK) == '0) && $stable(valid_q & BLK_MASK)); // R7
  AST_BLK_FLAGS: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && op == OP_BLK_INSERT && slot_ok) |=> dirty_q[$past(cmd_slot)] && !trap_q[$past(cmd_slot)]); // R8
  AST_REJ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && (op == OP_BLK_INSERT || op == OP_BLK_PURGE) && !slot_ok) |=> $stable(valid_q) && cmd_rej); // R9
  AST_BLK_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && op == OP_BLK_PURGE_ALL) |=> ((valid_q & BLK_MASK) == '0) && $stable(valid_q & NB_MASK)); // R10
endmodule

// File: tb/tlb_range_pinned_test.sv
module tlb_range_pinned_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_va = '0;
  logic [3:0]  cmd_size = '0;
  logic [39:0] cmd_pa = '0;
  logic [7:0]  cmd_attr = '0;
  logic        cmd_dirty = 1'b0, cmd_trap = 1'b0;
  logic [3:0]  cmd_slot = '0;
  logic        cmd_rej;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_dirty, lk_trap;
  logic [3:0]  lk_slot;
  logic [39:0] lk_pa;
  logic [7:0]  lk_attr;

  tlb_range_pinned uut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic        mv [16];
  logic [31:0] mb [16], ml [16];
  logic [39:0] mp [16];
  logic [7:0]  ma [16];
  logic        md [16], mt [16];
  int          rr;

  function automatic logic [31:0] mmask(input int s);
    int sh = 12 + 2 * s;
    if (sh >= 32) return 32'hFFFF_FFFF;
    return 32'((64'd1 << sh) - 64'd1);
  endfunction

  function automatic logic [39:0] msext(input logic [39:0] p);
    logic [39:0] r = p;
    r[39:36] = {4{p[35]}};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic m_purge(input logic [31:0] lo, input logic [31:0] hi);
    for (int i = 4; i < 16; i++)
      if (mv[i] && mb[i] <= hi && lo <= ml[i]) mv[i] = 1'b0;
  endtask

  task automatic m_apply(input logic [2:0] op, input logic [31:0] va, input logic [3:0] s,
                         input logic [39:0] pa, input logic [7:0] at, input logic d,
                         input logic t, input logic [3:0] sl, output logic rej);
    logic [31:0] m, lo, hi;
    logic [32:0] e;
    int v;
    rej = 1'b0;
    case (op)
      3'd1, 3'd4: begin
        m = mmask(int'(s)); lo = va & ~m; hi = lo | m;
        if (op == 3'd4 && sl >= 4) rej = 1'b1;
        else begin
          m_purge(lo, hi);
          if (op == 3'd4) v = int'(sl);
          else begin
            v = -1;
            for (int i = 15; i >= 4; i--) if (!mv[i]) v = i;
            if (v < 0) begin v = rr; rr = (rr == 15) ? 4 : rr + 1; end
          end
          mv[v] = 1'b1; mb[v] = lo; ml[v] = hi; mp[v] = msext(pa & ~{8'h00, m});
          ma[v] = at; md[v] = (op == 3'd4) ? 1'b1 : d; mt[v] = (op == 3'd4) ? 1'b0 : t;
        end
      end
      3'd2: begin
        m = mmask(int'(va[3:0])); lo = {va[31:12], 12'h000};
        e = {1'b0, lo} + {1'b0, m};
        hi = e[32] ? 32'hFFFF_FFFF : e[31:0];
        m_purge(lo, hi);
      end
      3'd3: begin for (int i = 4; i < 16; i++) mv[i] = 1'b0; rr = 4; end
      3'd5: if (sl < 4) mv[sl] = 1'b0; else rej = 1'b1;
      3'd6: for (int i = 0; i < 4; i++) mv[i] = 1'b0;
      default: ;
    endcase
  endtask

  function automatic logic [55:0] m_look(input logic [31:0] va);
    for (int i = 0; i < 16; i++)
      if (mv[i] && mb[i] <= va && va <= ml[i])
        return {1'b1, 4'(i), mp[i] + {8'h00, va - mb[i]}, ma[i], md[i], mt[i]};
    return '0;
  endfunction

  task automatic cmd(input string tag, input logic [2:0] op, input logic [31:0] va,
                     input logic [3:0] s, input logic [39:0] pa, input logic [7:0] at,
                     input logic d, input logic t, input logic [3:0] sl);
    logic erej;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_size = s; cmd_pa = pa;
    cmd_attr = at; cmd_dirty = d; cmd_trap = t; cmd_slot = sl;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    m_apply(op, va, s, pa, at, d, t, sl, erej);
    chk({tag, " cmd_rej R9"}, 64'(cmd_rej), 64'(erej));
  endtask

  task automatic look(input string tag, input logic [31:0] va);
    lk_va = va;
    #1;
    chk(tag, 64'({lk_hit, lk_slot, lk_pa, lk_attr, lk_dirty, lk_trap}), 64'(m_look(va)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_va;
    for (int i = 0; i < 16; i++) mv[i] = 1'b0;
    rr = 4;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    lk_va = 32'h0001_2345; #1;
    chk("R12 lk_hit after reset", 64'(lk_hit), 64'd0);
    chk("R12 cmd_rej after reset", 64'(cmd_rej), 64'd0);

    // R1 insert and range hit, R5 first free slot
    cmd("R1 insert", 3'd1, 32'h0001_2345, 4'd1, 40'h00_ABCD_E123, 8'h5A, 1'b0, 1'b1, 4'd0);
    lk_va = 32'h0001_3FFF; #1;
    chk("R1 top byte pa", 64'(lk_pa), 64'h00_ABCD_FFFF);
    chk("R5 first slot", 64'(lk_slot), 64'd4);
    lk_va = 32'h0001_4000; #1;
    chk("R1 past end misses", 64'(lk_hit), 64'd0);
    look("R1 base", 32'h0001_0000);

    // R2 sign extension of physical base
    cmd("R2 insert", 3'd1, 32'h4000_0000, 4'd0, 40'h08_1234_5678, 8'h11, 1'b1, 1'b0, 4'd0);
    lk_va = 32'h4000_0010; #1;
    chk("R2 pa sext", 64'(lk_pa), 64'hF8_1234_5010);
    chk("R5 second slot", 64'(lk_slot), 64'd5);

    // R3 overlapping insert replaces, reuses freed slot
    cmd("R3 insert", 3'd1, 32'h0001_8000, 4'd2, 40'h00_2000_0000, 8'h22, 1'b1, 1'b0, 4'd0);
    lk_va = 32'h0001_2000; #1;
    chk("R3 new entry slot", 64'(lk_slot), 64'd4);
    chk("R3 new entry pa", 64'(lk_pa), 64'h00_2000_2000);

    // R4 range purge
    cmd("R4 purge", 3'd2, 32'h4000_0000, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
    look("R4 purged miss", 32'h4000_0010);

    // R8 block insert forces flags
    cmd("R8 blk insert", 3'd4, 32'h8000_0000, 4'd3, 40'h00_0300_0000, 8'h33, 1'b0, 1'b1, 4'd1);
    lk_va = 32'h8003_FFFF; #1;
    chk("R8 dirty/trap forced", 64'({lk_hit, lk_slot, lk_dirty, lk_trap}), 64'({1'b1, 4'd1, 1'b1, 1'b0}));
    cmd("R4 purge over block", 3'd2, 32'h8000_0003, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h8000_0000; #1;
    chk("R4 block survives", 64'(lk_hit), 64'd1);

    // R9 rejects
    cmd("R9 blk insert slot7", 3'd4, 32'h9000_0000, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd7);
    lk_va = 32'h9000_0000; #1;
    chk("R9 rejected insert misses", 64'(lk_hit), 64'd0);
    cmd("R9 blk purge slot9", 3'd5, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd9);
    look("R9 nonblock kept", 32'h0001_2000);

    // R7 purge-all, R6 round robin
    cmd("R7 purge all", 3'd3, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h0001_2000; #1;
    chk("R7 nonblock gone", 64'(lk_hit), 64'd0);
    lk_va = 32'h8000_1000; #1;
    chk("R7 block kept", 64'(lk_hit), 64'd1);
    for (int i = 0; i < 12; i++)
      cmd("R5 fill", 3'd1, 32'h0020_0000 + 32'(i) * 32'h1000, 4'd0, 40'h1000 * 40'(i), 8'(i), 1'b1, 1'b0, 4'd0);
    lk_va = 32'h0020_B000; #1;
    chk("R5 fill last slot", 64'(lk_slot), 64'd15);
    cmd("R6 evict", 3'd1, 32'h0030_0000, 4'd0, 40'h7000, 8'h70, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h0030_0000; #1;
    chk("R6 rr first victim", 64'(lk_slot), 64'd4);
    look("R6 evicted miss", 32'h0020_0000);
    cmd("R6 evict2", 3'd1, 32'h0030_1000, 4'd0, 40'h8000, 8'h71, 1'b0, 1'b0, 4'd0);
    cmd("R5 free one", 3'd2, 32'h0020_5000, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
    cmd("R5 reuse", 3'd1, 32'h0030_2000, 4'd0, 40'h9000, 8'h72, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h0030_2000; #1;
    chk("R5 free before rr", 64'(lk_slot), 64'd9);
    cmd("R6 evict3", 3'd1, 32'h0030_3000, 4'd0, 40'hA000, 8'h73, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h0030_3000; #1;
    chk("R6 rr not moved by free use", 64'(lk_slot), 64'd6);

    // same-cycle lookup and purge (R4)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_va = 32'h0030_3000; lk_va = 32'h0030_3000;
    #1;
    chk("R4 lookup before edge sees old", 64'(lk_hit), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    begin logic r; m_apply(3'd2, 32'h0030_3000, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0, r); end
    #1;
    chk("R4 lookup after edge misses", 64'(lk_hit), 64'd0);

    // R11 priority among block slots, R10 block purges
    cmd("R11 blk2", 3'd4, 32'h5000_0000, 4'd2, 40'h00_0100_0000, 8'hB2, 1'b0, 1'b0, 4'd2);
    cmd("R11 blk0", 3'd4, 32'h5000_0000, 4'd0, 40'h00_0200_0000, 8'hB0, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h5000_0004; #1;
    chk("R11 lowest wins", 64'(lk_slot), 64'd0);
    lk_va = 32'h5000_1004; #1;
    chk("R11 other part", 64'(lk_slot), 64'd2);
    cmd("R10 blk purge", 3'd5, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
    look("R10 after slot purge", 32'h5000_0004);
    cmd("R10 blk purge all", 3'd6, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
    lk_va = 32'h8000_0000; #1;
    chk("R10 block gone", 64'(lk_hit), 64'd0);
    lk_va = 32'h0030_2000; #1;
    chk("R10 nonblock kept", 64'(lk_hit), 64'd1);
    cmd("R1 whole space", 3'd4, 32'h1234_5678, 4'd12, 40'h0, 8'hEE, 1'b0, 1'b0, 4'd3);
    look("R1 saturated span", 32'hFFFF_FFF0);
    cmd("R10 clear", 3'd6, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);

    // random traffic (R3 R5 R6 R1 mixed)
    last_va = 32'h0;
    for (int it = 0; it < 1500; it++) begin
      int k = int'($urandom % 100);
      logic [31:0] va = 32'h0010_0000 * ($urandom % 4) + ($urandom % 32'h0004_0000);
      logic [3:0] s = (($urandom % 20) == 0) ? 4'($urandom % 16) : 4'($urandom % 4);
      logic [39:0] pa = {8'($urandom), 32'($urandom)};
      if (k < 45) begin
        cmd("R3 rnd insert", 3'd1, va, s, pa, 8'($urandom), 1'($urandom), 1'($urandom), 4'd0);
        last_va = va;
      end else if (k < 62)
        cmd("R4 rnd purge", 3'd2, {va[31:4], 4'($urandom % 4)}, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
      else if (k < 72)
        cmd("R8 rnd blk insert", 3'd4, va, s, pa, 8'($urandom), 1'b0, 1'b1, 4'($urandom % 6));
      else if (k < 77)
        cmd("R10 rnd blk purge", 3'd5, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'($urandom % 6));
      else if (k < 79)
        cmd("R7 rnd purge all", 3'd3, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
      else if (k < 80)
        cmd("R10 rnd blk purge all", 3'd6, 32'h0, 4'd0, 40'h0, 8'h0, 1'b0, 1'b0, 4'd0);
      look("R1 rnd lookup", va);
      look("R11 rnd lookup recent", last_va);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule